// File: doc/BRIEF.md
# Clock Rate and Stall Monitor

This block watches one fast clock, the measured clock, against a slow free-running reference clock. While measurement is enabled, the reference domain opens a counting window one reference period long. The measured domain counts its own rising edges inside that window and returns the total through a toggle handshake. The reference domain compares the total against an inclusive lower and upper bound. A total above the upper bound raises a too-fast flag, and a total below the lower bound raises a too-slow flag. If the returned handshake does not arrive within a fixed number of reference cycles, the measured clock is taken to have stopped and a stall flag is raised.

The three flags are sticky and recoverable. Each one stays set until a one is written to its own clear bit. The enable and both bounds sit behind a write gate. Pulsing the lock input closes the gate, and only a reset opens it again. The first result after measurement is enabled, and the first result after a stall, is thrown away. This stops a window that straddled the change from raising a false flag.

Top module: `clk_rate_monitor`

## Requirements
- R1: While enabled, the reference domain opens the counting window for exactly one reference cycle at a time, and the measured domain counts every measured-clock rising edge in that window. With a 10 ns measured clock and a 170 ns reference clock, the total is 17.
- R2: When an accepted total is greater than the upper bound, `err_fast_o` goes high.
- R3: When an accepted total is less than the lower bound, `err_slow_o` goes high.
- R4: The bounds are inclusive. A total equal to both bounds raises no flag.
- R5: When the measured clock stops, `err_timeout_o` goes high once TIMEOUT_CYC reference cycles pass with no handshake return. A running clock never raises it.
- R6: Every flag holds until its clear bit is written with a one. Clear bit 0 clears too-fast, bit 1 clears too-slow and bit 2 clears stall.
- R7: The first total returned after measurement is enabled is discarded, and so is the first total after a stall.
- R8: While measurement is disabled, no window opens and no flag is raised, whatever the bounds hold.
- R9: `cfg_unlocked_o` is 1 after reset and drops to 0 on a `lock_i` pulse. It then stays 0 until reset, and configuration writes made while it is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Slow always-on reference clock |
| meas_clk_i | input | 1 | Clock under measurement |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| cfg_we_i | input | 1 | Write strobe for enable and bounds |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_min_i | input | CNT_W | Lower bound to write |
| cfg_max_i | input | CNT_W | Upper bound to write |
| lock_i | input | 1 | Pulse that closes the write gate |
| err_clr_i | input | 3 | Write-one clear: bit0 fast, bit1 slow, bit2 stall |
| cfg_unlocked_o | output | 1 | Write gate state |
| err_fast_o | output | 1 | Sticky too-fast flag |
| err_slow_o | output | 1 | Sticky too-slow flag |
| err_timeout_o | output | 1 | Sticky stall flag |

## Verification
The hardest case to reach from the ports is the discarded first result. A full window is completed before any flag can appear, so a design that skips the discard differs from a correct one by only four reference cycles. The bench enables measurement with an upper bound of zero and samples the too-fast flag at two points. The first point falls after the discarded result would have landed but before the second one. The second point falls after the second result lands. Stall detection is reached by gating the measured clock in the bench and later restarting it, which also exercises handshake returns that arrive late.

// File: rtl/crm_pkg.sv
`timescale 1ns/1ps
package crm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_WAIT = 2'd2
  } win_state_e;

  localparam int unsigned ERR_FAST = 0;
  localparam int unsigned ERR_SLOW = 1;
  localparam int unsigned ERR_TMO  = 2;
  localparam int unsigned ERR_N    = 3;

  // saturating increment, lim is the largest representable count
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // {slow, fast} verdict of a total against inclusive bounds
  function automatic logic [1:0] judge(input logic [31:0] cnt, input logic [31:0] lo,
                                       input logic [31:0] hi);
    return {cnt < lo, cnt > hi};
  endfunction
endpackage

// File: rtl/crm_sync.sv
`timescale 1ns/1ps
module crm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/crm_cfg.sv
`timescale 1ns/1ps
module crm_cfg #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             lock_i,
  output logic             unlocked_o,
  output logic             en_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);
  logic write_ok;

  assign write_ok = we_i && unlocked_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     unlocked_o <= 1'b1;
    else if (lock_i) unlocked_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      min_o <= '0;
      max_o <= '1;
    end else if (write_ok) begin
      en_o  <= en_i;
      min_o <= min_i;
      max_o <= max_i;
    end
  end
endmodule

// File: rtl/crm_meas.sv
`timescale 1ns/1ps
module crm_meas import crm_pkg::*; #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             ack_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             win_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             win_rise, win_fall;

  assign win_rise = win_i && !win_prev_q;
  assign win_fall = !win_i && win_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_prev_q <= 1'b0;
      cnt_q      <= '0;
      hold_o     <= '0;
      ack_tgl_o  <= 1'b0;
    end else begin
      win_prev_q <= win_i;
      if (win_rise)   cnt_q <= CNT_W'(1);
      else if (win_i) cnt_q <= CNT_W'(sat_inc(32'(cnt_q), 32'(CNT_TOP)));
      if (win_fall) begin
        hold_o    <= cnt_q;
        ack_tgl_o <= !ack_tgl_o;
      end
    end
  end
endmodule

// File: rtl/crm_ctl.sv
`timescale 1ns/1ps
module crm_ctl import crm_pkg::*; #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned TIMEOUT_CYC = 4,
  localparam int unsigned TW         = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             ack_sync_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [ERR_N-1:0] err_clr_i,
  output logic             win_o,
  output logic [ERR_N-1:0] err_o,
  output logic             res_take_o,
  output logic [CNT_W-1:0] res_cnt_o,
  output logic             tmo_hit_o,
  output logic [TW-1:0]    wait_cnt_o
);
  win_state_e       state_q, state_d;
  logic             ack_prev_q, discard_q;
  logic [TW-1:0]    wait_q;
  logic             ack_evt, in_wait;
  logic [1:0]       verdict;
  logic [ERR_N-1:0] set_vec;

  assign ack_evt    = ack_sync_i ^ ack_prev_q;
  assign in_wait    = en_i && (state_q == ST_WAIT);
  assign tmo_hit_o  = in_wait && !ack_evt && (wait_q == TW'(TIMEOUT_CYC - 1));
  assign res_take_o = in_wait && ack_evt && !discard_q;
  assign res_cnt_o  = hold_i;
  assign verdict    = judge(32'(hold_i), 32'(min_i), 32'(max_i));
  assign win_o      = (state_q == ST_OPEN);
  assign wait_cnt_o = wait_q;

  assign set_vec[ERR_FAST] = res_take_o && verdict[0];
  assign set_vec[ERR_SLOW] = res_take_o && verdict[1];
  assign set_vec[ERR_TMO]  = tmo_hit_o;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_OPEN;
        ST_OPEN: state_d = ST_WAIT;
        ST_WAIT: if (ack_evt || tmo_hit_o) state_d = ST_OPEN;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ack_prev_q <= 1'b0;
      discard_q  <= 1'b1;
      wait_q     <= '0;
    end else begin
      state_q    <= state_d;
      ack_prev_q <= ack_sync_i;
      wait_q     <= (in_wait && !ack_evt && !tmo_hit_o) ? wait_q + 1'b1 : '0;
      if (!en_i || tmo_hit_o)   discard_q <= 1'b1;
      else if (in_wait && ack_evt) discard_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         err_o[i] <= 1'b0;
      else if (set_vec[i]) err_o[i] <= 1'b1;
      else if (err_clr_i[i]) err_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_rate_monitor.sv
`timescale 1ns/1ps
module clk_rate_monitor import crm_pkg::*; #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned TIMEOUT_CYC = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TW         = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             ref_clk_i,
  input  logic             meas_clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic [CNT_W-1:0] cfg_min_i,
  input  logic [CNT_W-1:0] cfg_max_i,
  input  logic             lock_i,
  input  logic [2:0]       err_clr_i,
  output logic             cfg_unlocked_o,
  output logic             err_fast_o,
  output logic             err_slow_o,
  output logic             err_timeout_o
);
  logic             en_q;
  logic [CNT_W-1:0] min_q, max_q;
  logic             win_ref, win_meas;
  logic             ack_meas, ack_ref;
  logic [CNT_W-1:0] hold_cnt, res_cnt;
  logic             res_take, tmo_hit;
  logic [TW-1:0]    wait_cnt;
  logic [ERR_N-1:0] err_vec;

  crm_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .en_i(cfg_en_i),
    .min_i(cfg_min_i), .max_i(cfg_max_i), .lock_i(lock_i),
    .unlocked_o(cfg_unlocked_o), .en_o(en_q), .min_o(min_q), .max_o(max_q)
  );

  crm_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
    .clk_i(meas_clk_i), .rst_ni(rst_ni), .d_i(win_ref), .q_o(win_meas)
  );

  crm_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i(meas_clk_i), .rst_ni(rst_ni), .win_i(win_meas),
    .hold_o(hold_cnt), .ack_tgl_o(ack_meas)
  );

  crm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(ack_meas), .q_o(ack_ref)
  );

  crm_ctl #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctl (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(en_q), .min_i(min_q), .max_i(max_q),
    .ack_sync_i(ack_ref), .hold_i(hold_cnt), .err_clr_i(err_clr_i),
    .win_o(win_ref), .err_o(err_vec), .res_take_o(res_take), .res_cnt_o(res_cnt),
    .tmo_hit_o(tmo_hit), .wait_cnt_o(wait_cnt)
  );

  assign err_fast_o    = err_vec[ERR_FAST];
  assign err_slow_o    = err_vec[ERR_SLOW];
  assign err_timeout_o = err_vec[ERR_TMO];
endmodule

// File: rtl/crm_chk.sv
`timescale 1ns/1ps
module crm_chk #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned TIMEOUT_CYC = 4,
  localparam int unsigned TW         = $clog2(TIMEOUT_CYC + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic [CNT_W-1:0] min_q,
  input logic [CNT_W-1:0] max_q,
  input logic             win_ref,
  input logic             res_take,
  input logic [CNT_W-1:0] res_cnt,
  input logic             tmo_hit,
  input logic [TW-1:0]    wait_cnt,
  input logic [2:0]       err_clr,
  input logic [2:0]       err_vec,
  input logic             unlocked
);
  AST_WIN_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_ref |=> !win_ref); // R1
  AST_FAST_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_take && (res_cnt > max_q)) |=> err_vec[0]); // R2
  AST_SLOW_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_take && (res_cnt < min_q)) |=> err_vec[1]); // R3
  AST_IN_RANGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_vec[0] && !(res_take && (res_cnt > max_q))) |=> !err_vec[0]); // R4
  AST_STALL_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_hit |=> err_vec[2]); // R5
  AST_WAIT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt < TW'(TIMEOUT_CYC)); // R5
  for (genvar i = 0; i < 3; i++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_vec[i] && !err_clr[i]) |=> err_vec[i]); // R6
  end
  AST_IDLE_NO_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !win_ref); // R8
  AST_LOCK_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> !unlocked); // R9
  AST_LOCK_FREEZES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> ($stable(max_q) && $stable(min_q) && $stable(en_q))); // R9
endmodule

bind clk_rate_monitor crm_chk #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i(ref_clk_i), .rst_ni(rst_ni), .en_q(en_q), .min_q(min_q), .max_q(max_q),
  .win_ref(win_ref), .res_take(res_take), .res_cnt(res_cnt), .tmo_hit(tmo_hit),
  .wait_cnt(wait_cnt), .err_clr(err_clr_i), .err_vec(err_vec), .unlocked(cfg_unlocked_o)
);

// File: tb/clk_rate_monitor_test.sv
`timescale 1ns/1ps
module clk_rate_monitor_test;
  localparam int REF_HALF   = 85;
  localparam int REF_PERIOD = 2 * REF_HALF;
  localparam int CNT_W      = 10;

  logic ref_clk = 1'b0, meas_clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, lock = 1'b0;
  logic [CNT_W-1:0] cfg_min = '0, cfg_max = '0;
  logic [2:0] err_clr = '0;
  logic unlocked, err_fast, err_slow, err_tmo;

  int  meas_half = 5;
  bit  meas_run = 1'b1;
  int  n_checks = 0, n_fails = 0;
  bit  mon_on = 1'b0, finished = 1'b0;
  bit  allow_fast = 1'b0, allow_slow = 1'b0, allow_tmo = 1'b0;
  bit  m_unl;

  clk_rate_monitor uut (
    .ref_clk_i(ref_clk), .meas_clk_i(meas_clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_min_i(cfg_min), .cfg_max_i(cfg_max),
    .lock_i(lock), .err_clr_i(err_clr), .cfg_unlocked_o(unlocked),
    .err_fast_o(err_fast), .err_slow_o(err_slow), .err_timeout_o(err_tmo)
  );

  initial begin
    #2;
    forever #REF_HALF ref_clk = ~ref_clk;
  end

  always begin
    if (meas_run) #(meas_half) meas_clk = ~meas_clk;
    else #1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural model of the write gate, and per-cycle flag permission check
  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)    m_unl <= 1'b1;
    else if (lock) m_unl <= 1'b0;
  end

  always @(negedge ref_clk) begin
    if (mon_on) begin
      chk(unlocked == m_unl, "R9", "gate state", int'(unlocked), int'(m_unl));
      chk(!(err_fast && !allow_fast), "R2", "unexpected fast flag", int'(err_fast), 0);
      chk(!(err_slow && !allow_slow), "R3", "unexpected slow flag", int'(err_slow), 0);
      chk(!(err_tmo && !allow_tmo), "R5", "unexpected stall flag", int'(err_tmo), 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic cfg_write(input bit en, input int lo, input int hi);
    @(negedge ref_clk);
    cfg_we = 1'b1; cfg_en = en; cfg_min = CNT_W'(lo); cfg_max = CNT_W'(hi);
    @(negedge ref_clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all;
    @(negedge ref_clk);
    err_clr = 3'b111;
    @(negedge ref_clk);
    err_clr = 3'b000;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(REF_PERIOD * 5000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nominal;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    mon_on = 1'b1;
    // reset state
    chk(!err_fast && !err_slow && !err_tmo, "R6", "flags after reset",
        int'({err_tmo, err_slow, err_fast}), 0);
    chk(unlocked == 1'b1, "R9", "gate after reset", int'(unlocked), 1);

    // R1 R4: exact total equal to both bounds
    nominal = REF_PERIOD / (2 * meas_half);
    cfg_write(1'b1, nominal, nominal);
    tick(40);
    chk(!err_fast && !err_slow, "R4", "in-range flags",
        int'({err_slow, err_fast}), 0);

    // R2: upper bound one below the total
    allow_fast = 1'b1;
    cfg_write(1'b1, 0, nominal - 1);
    tick(15);
    chk(err_fast == 1'b1, "R2", "fast flag", int'(err_fast), 1);
    chk(err_slow == 1'b0, "R1", "slow flag with exact total", int'(err_slow), 0);
    cfg_write(1'b0, 0, nominal - 1);
    tick(10);
    chk(err_fast == 1'b1, "R6", "fast flag held", int'(err_fast), 1);
    clear_all();
    tick(1);
    chk(err_fast == 1'b0, "R6", "fast flag cleared", int'(err_fast), 0);
    allow_fast = 1'b0;

    // R3: lower bound one above the total
    allow_slow = 1'b1;
    cfg_write(1'b1, nominal + 1, 1023);
    tick(15);
    chk(err_slow == 1'b1, "R3", "slow flag", int'(err_slow), 1);
    chk(err_fast == 1'b0, "R3", "fast flag during slow", int'(err_fast), 0);
    cfg_write(1'b0, 0, 1023);
    tick(6);
    clear_all();
    tick(1);
    chk(err_slow == 1'b0, "R6", "slow flag cleared", int'(err_slow), 0);
    allow_slow = 1'b0;
    tick(10);

    // R7: first total after enable is thrown away
    allow_fast = 1'b1;
    cfg_write(1'b1, 0, 0);
    tick(7);
    chk(err_fast == 1'b0, "R7", "flag after discarded total", int'(err_fast), 0);
    tick(5);
    chk(err_fast == 1'b1, "R7", "flag after second total", int'(err_fast), 1);
    cfg_write(1'b0, 0, 0);
    tick(6);
    clear_all();
    tick(1);
    allow_fast = 1'b0;

    // R8: disabled with impossible bounds
    cfg_write(1'b0, 1000, 0);
    tick(30);
    chk(!err_fast && !err_slow && !err_tmo, "R8", "flags while disabled",
        int'({err_tmo, err_slow, err_fast}), 0);

    // R2 R3 with other clock rates
    meas_half = 2;
    tick(4);
    allow_fast = 1'b1;
    cfg_write(1'b1, 17, 20);
    tick(15);
    chk(err_fast == 1'b1, "R2", "fast flag at 4 ns clock", int'(err_fast), 1);
    cfg_write(1'b0, 0, 1023);
    tick(6);
    clear_all();
    tick(1);
    allow_fast = 1'b0;
    meas_half = 10;
    tick(4);
    allow_slow = 1'b1;
    cfg_write(1'b1, 12, 20);
    tick(15);
    chk(err_slow == 1'b1, "R3", "slow flag at 20 ns clock", int'(err_slow), 1);
    cfg_write(1'b0, 0, 1023);
    tick(6);
    clear_all();
    tick(1);
    allow_slow = 1'b0;
    meas_half = 5;

    // R5: stall detection
    cfg_write(1'b1, 0, 1023);
    tick(20);
    chk(err_tmo == 1'b0, "R5", "stall flag while running", int'(err_tmo), 0);
    allow_tmo = 1'b1;
    meas_run = 1'b0;
    tick(12);
    chk(err_tmo == 1'b1, "R5", "stall flag after stop", int'(err_tmo), 1);
    meas_run = 1'b1;
    tick(10);
    clear_all();
    tick(2);
    allow_tmo = 1'b0;
    tick(30);
    chk(err_tmo == 1'b0, "R5", "stall flag after restart", int'(err_tmo), 0);

    // R9: lock, then a write that would raise a flag is ignored
    @(negedge ref_clk);
    lock = 1'b1;
    @(negedge ref_clk);
    lock = 1'b0;
    chk(unlocked == 1'b0, "R9", "gate closed", int'(unlocked), 0);
    cfg_write(1'b1, 1000, 0);
    tick(25);
    chk(!err_fast && !err_slow, "R9", "flags after ignored write",
        int'({err_slow, err_fast}), 0);
    chk(unlocked == 1'b0, "R9", "gate stays closed", int'(unlocked), 0);

    finish_run();
  end
endmodule